// File: doc/BRIEF.md
# Frame-Synced Serial Word Receiver

This block receives boot data over a synchronous serial link in which the sender drives both the bit clock and the frame sync. Each frame carries one word of either 8 or 16 bits, chosen by a mode input. The first data bit follows its frame sync pulse by one bit clock. All three serial lines are brought into the system clock domain through multi-stage synchronizers. The receiver acts on each detected rising edge of the synchronized bit clock and shifts the data in most significant bit first.

A completed word is held on a parallel output with a valid flag until the consumer acknowledges it. A wait pin tells the sender when it must pause. The pin is high while a received word is still waiting to be taken, or while the downstream logic signals that it is busy, for example during a programmed delay. It is low when a new word can be accepted. If a word completes while the previous one has not been taken, the block latches a sticky overrun error and keeps the older word. Only reset clears the error.

Top module: `ser_word_rx`

## Requirements
- R1: After synchronous reset, `rx_valid` is 0, `rx_word` is 0 and `overrun_err` is 0, and `rx_wait` is 0 while `busy_in` is 0.
- R2: With `wide_mode`=0, a frame delivers 8 data bits, MSB first, right-justified in `rx_word[7:0]`, and `rx_word[15:8]` is 0.
- R3: With `wide_mode`=1, a frame delivers 16 data bits, MSB first, into `rx_word[15:0]`.
- R4: The data line value at the bit clock rising edge on which frame sync is high is not part of the word. The first data bit is taken at the next rising edge.
- R5: Once `rx_valid` rises, it stays high and `rx_word` stays unchanged until a cycle with `word_take`=1. That cycle clears `rx_valid`, unless a new word completes in the same cycle.
- R6: `rx_wait` is high whenever `rx_valid` or `busy_in` is high, and low otherwise.
- R7: A word that completes while `rx_valid` is high and `word_take` is 0 sets `overrun_err`. The held word is not replaced. `overrun_err` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Bit clock from the sender, asynchronous |
| fsync_in | input | 1 | Frame sync from the sender, one pulse per word |
| sdata_in | input | 1 | Serial data from the sender |
| wide_mode | input | 1 | 1 selects 16-bit words, 0 selects 8-bit words |
| word_take | input | 1 | Consumer acknowledges the held word |
| busy_in | input | 1 | Downstream busy (copy or delay in progress) |
| rx_word | output | 16 | Received word, right-justified |
| rx_valid | output | 1 | A received word is held |
| rx_wait | output | 1 | High tells the sender to hold off |
| overrun_err | output | 1 | Sticky overrun error |

## Verification
The bench builds the block with its default two-stage synchronizer. Its reference model therefore places every bit clock edge exactly three system clocks before the shift register acts on it, and one more clock before the word appears. The bit clock runs at one eighth of the system clock. This leaves enough margin to drive frames in both word lengths and to place a deliberately high data bit on the sync edge. It also reaches the overrun case by sending two frames back to back without an acknowledge.

// File: rtl/ser_rx_pkg.sv
package ser_rx_pkg;

    localparam int unsigned WIDE_BITS   = 16;
    localparam int unsigned NARROW_BITS = 8;
    localparam int unsigned CNT_W       = $clog2(WIDE_BITS + 1);

    typedef logic [WIDE_BITS-1:0] word_t;
    typedef logic [CNT_W-1:0]     bitcnt_t;

    typedef enum logic {
        ST_WAIT_FS,
        ST_SHIFT
    } rx_state_e;

    typedef struct packed {
        logic  done;
        word_t data;
    } rx_beat_t;

    function automatic bitcnt_t bits_for_mode(input logic wide);
        return wide ? bitcnt_t'(WIDE_BITS) : bitcnt_t'(NARROW_BITS);
    endfunction

endpackage

// File: rtl/ser_rx_sync.sv
module ser_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ser_rx_deser.sv
module ser_rx_deser
    import ser_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bclk_s,
    input  logic     fs_s,
    input  logic     sd_s,
    input  logic     wide,
    output rx_beat_t beat
);
    localparam bitcnt_t ONE = bitcnt_t'(1);

    rx_state_e state;
    bitcnt_t   cnt;
    bitcnt_t   len;
    word_t     sh;
    logic      bclk_prev;
    logic      rise;
    word_t     sh_next;

    assign rise    = bclk_s & ~bclk_prev;
    assign sh_next = {sh[WIDE_BITS-2:0], sd_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_WAIT_FS;
            cnt       <= '0;
            len       <= bitcnt_t'(NARROW_BITS);
            sh        <= '0;
            bclk_prev <= 1'b0;
            beat      <= '0;
        end else begin
            bclk_prev <= bclk_s;
            beat.done <= 1'b0;
            if (rise) begin
                case (state)
                    ST_WAIT_FS: begin
                        if (fs_s) begin
                            state <= ST_SHIFT;
                            cnt   <= '0;
                            sh    <= '0;
                            len   <= bits_for_mode(wide);
                        end
                    end
                    ST_SHIFT: begin
                        sh  <= sh_next;
                        cnt <= cnt + ONE;
                        if (cnt == len - ONE) begin
                            beat.done <= 1'b1;
                            beat.data <= sh_next;
                            state     <= ST_WAIT_FS;
                        end
                    end
                    default: state <= ST_WAIT_FS;
                endcase
            end
        end
    end
endmodule

// File: rtl/ser_rx_hold.sv
module ser_rx_hold
    import ser_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_beat_t beat,
    input  logic     take,
    input  logic     busy,
    output word_t    word,
    output logic     valid,
    output logic     wait_o,
    output logic     err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word  <= '0;
            valid <= 1'b0;
            err   <= 1'b0;
        end else if (beat.done) begin
            if (valid && !take) begin
                err <= 1'b1;
            end else begin
                word  <= beat.data;
                valid <= 1'b1;
            end
        end else if (take) begin
            valid <= 1'b0;
        end
    end

    assign wait_o = valid | busy;
endmodule

// File: rtl/ser_word_rx.sv
module ser_word_rx
    import ser_rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bclk_in,
    input  logic                 fsync_in,
    input  logic                 sdata_in,
    input  logic                 wide_mode,
    input  logic                 word_take,
    input  logic                 busy_in,
    output logic [WIDE_BITS-1:0] rx_word,
    output logic                 rx_valid,
    output logic                 rx_wait,
    output logic                 overrun_err
);
    localparam int unsigned NUM_LINES = 3;

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] sync_lines;
    rx_beat_t             beat;

    assign raw_lines = {sdata_in, fsync_in, bclk_in};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_sync
        ser_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw_lines[g]),
            .q   (sync_lines[g])
        );
    end

    ser_rx_deser u_deser (
        .clk    (clk),
        .rst    (rst),
        .bclk_s (sync_lines[0]),
        .fs_s   (sync_lines[1]),
        .sd_s   (sync_lines[2]),
        .wide   (wide_mode),
        .beat   (beat)
    );

    ser_rx_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .beat   (beat),
        .take   (word_take),
        .busy   (busy_in),
        .word   (rx_word),
        .valid  (rx_valid),
        .wait_o (rx_wait),
        .err    (overrun_err)
    );
endmodule

// File: rtl/ser_word_rx_chk.sv
module ser_word_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic        rx_valid,
    input logic        word_take,
    input logic        rx_wait,
    input logic        overrun_err,
    input logic [15:0] rx_word
);
    assert_word_held_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !word_take) |=> (rx_valid && $stable(rx_word)));

    assert_wait_when_full_R6: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rx_wait);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        overrun_err |=> overrun_err);

    assert_err_needs_word_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun_err) |-> rx_valid);
endmodule

bind ser_word_rx ser_word_rx_chk u_chk (.*);

// File: tb/ser_word_rx_tb.sv
`timescale 1ns/1ps
module ser_word_rx_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk_in = 1'b0, fsync_in = 1'b0, sdata_in = 1'b0;
    logic        wide_mode = 1'b0, word_take = 1'b0, busy_in = 1'b0;
    logic [15:0] rx_word;
    logic        rx_valid, rx_wait, overrun_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ser_word_rx u_dut (
        .clk(clk), .rst(rst), .bclk_in(bclk_in), .fsync_in(fsync_in),
        .sdata_in(sdata_in), .wide_mode(wide_mode), .word_take(word_take),
        .busy_in(busy_in), .rx_word(rx_word), .rx_valid(rx_valid),
        .rx_wait(rx_wait), .overrun_err(overrun_err)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: input history delayed by the synchronizer depth,
    // frame tracking with integers, and a one-entry output slot.
    bit h1b, h1f, h1d, h2b, h2f, h2d, h3b;
    int m_state, m_cnt, m_len, m_sh, m_word, m_pend_word;
    bit m_pend, m_full, m_err;

    always @(posedge clk) begin
        if (rst) begin
            {h1b, h1f, h1d, h2b, h2f, h2d, h3b} = '0;
            m_state = 0; m_cnt = 0; m_len = 8; m_sh = 0;
            m_word = 0; m_pend_word = 0; m_pend = 0; m_full = 0; m_err = 0;
        end else begin
            if (m_pend) begin
                if (m_full && !word_take) m_err = 1;
                else begin m_word = m_pend_word; m_full = 1; end
            end else if (word_take) m_full = 0;
            m_pend = 0;
            if (h2b && !h3b) begin
                if (m_state == 0) begin
                    if (h2f) begin
                        m_state = 1; m_cnt = 0; m_sh = 0;
                        m_len = wide_mode ? 16 : 8;
                    end
                end else begin
                    m_sh = ((m_sh << 1) | int'(h2d)) & 16'hFFFF;
                    m_cnt++;
                    if (m_cnt == m_len) begin
                        m_pend = 1; m_pend_word = m_sh; m_state = 0;
                    end
                end
            end
            h3b = h2b;
            h2b = h1b; h2f = h1f; h2d = h1d;
            h1b = bclk_in; h1f = fsync_in; h1d = sdata_in;
        end
        #1;
        check_eq("R5", "model rx_valid", int'(rx_valid), int'(m_full));
        check_eq("R2", "model rx_word", int'(rx_word), m_word);
        check_eq("R7", "model overrun_err", int'(overrun_err), int'(m_err));
        check_eq("R6", "model rx_wait", int'(rx_wait), int'(m_full | busy_in));
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input int width, input int val, input bit sync_bit);
        for (int i = -1; i < width; i++) begin
            bclk_in  = 1'b0;
            fsync_in = (i < 0);
            sdata_in = (i < 0) ? sync_bit : val[width-1-i];
            tick(4);
            bclk_in = 1'b1;
            tick(4);
        end
        bclk_in = 1'b0; fsync_in = 1'b0; sdata_in = 1'b0;
        tick(12);
    endtask

    task automatic take_once();
        word_take = 1'b1; tick(1); word_take = 1'b0; tick(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(2);
        check_eq("R1", "rx_valid after reset", int'(rx_valid), 0);
        check_eq("R1", "rx_word after reset", int'(rx_word), 0);
        check_eq("R1", "overrun_err after reset", int'(overrun_err), 0);
        check_eq("R1", "rx_wait after reset", int'(rx_wait), 0);

        // R2, R4: 8-bit word, high data bit on the sync edge must be dropped
        wide_mode = 1'b0;
        send_word(8, 'hA5, 1'b1);
        check_eq("R2", "8-bit word", int'(rx_word), 'h00A5);
        check_eq("R4", "sync-edge bit excluded", int'(rx_word[15:8]), 0);
        check_eq("R6", "wait while full", int'(rx_wait), 1);
        tick(5);
        check_eq("R5", "word held without take", int'(rx_word), 'h00A5);
        take_once();
        check_eq("R5", "valid cleared by take", int'(rx_valid), 0);
        check_eq("R6", "wait low when empty", int'(rx_wait), 0);

        // R3: 16-bit word
        wide_mode = 1'b1;
        send_word(16, 'hC3E1, 1'b0);
        check_eq("R3", "16-bit word", int'(rx_word), 'hC3E1);
        check_eq("R3", "valid for 16-bit", int'(rx_valid), 1);
        take_once();

        // R4: sync-edge bit high before a word whose MSB is zero
        send_word(16, 'h0001, 1'b1);
        check_eq("R4", "16-bit with sync-edge bit high", int'(rx_word), 'h0001);
        take_once();

        // R6: busy input alone raises wait
        busy_in = 1'b1; tick(2);
        check_eq("R6", "wait from busy", int'(rx_wait), 1);
        busy_in = 1'b0; tick(2);
        check_eq("R6", "wait drops after busy", int'(rx_wait), 0);

        // R7: overrun
        wide_mode = 1'b0;
        send_word(8, 'h3C, 1'b0);
        check_eq("R7", "no error before overrun", int'(overrun_err), 0);
        send_word(8, 'hF0, 1'b0);
        check_eq("R7", "overrun flagged", int'(overrun_err), 1);
        check_eq("R7", "older word kept", int'(rx_word), 'h003C);
        take_once();
        check_eq("R7", "error sticky after take", int'(overrun_err), 1);
        send_word(8, 'h81, 1'b0);
        check_eq("R7", "error sticky across words", int'(overrun_err), 1);
        check_eq("R2", "word after overrun", int'(rx_word), 'h0081);

        rst = 1'b1; tick(3); rst = 1'b0; tick(2);
        check_eq("R1", "error cleared by reset", int'(overrun_err), 0);
        check_eq("R1", "valid cleared by reset", int'(rx_valid), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule